// File: doc/BRIEF.md
# Entropy request command sequencer

This block sits in front of a random-number generator's command port and decides which command words go out on it. Commands go out as a stream of 32-bit words with a valid/ready handshake. The generator answers each complete command with a one-cycle acknowledge and a 2-bit status code. Bits [3:0] of a command's first word give its kind: 1 is instantiate, 2 is reseed and 3 is generate. Bits [7:4] give how many data words follow that first word. The sequencer sends the whole command and then waits for the acknowledge before it sends anything else.

There are three ways to drive the port:
- **Boot mode.** Hardware sends one instantiate word and then one generate word, both taken from input buses, and then goes quiet.
- **Software mode.** Firmware writes command words one at a time. Each word is forwarded as it arrives, and the sequencer records how the command ended.
- **Auto mode.** Firmware sends the first instantiate through the software path. Once that is acknowledged, hardware keeps replaying a stored generate command. It swaps in a stored reseed command each time a request countdown runs out.

Stored commands sit in two small write-once replay buffers. A sparse-coded state machine drives the whole block. Any state code it does not recognise locks it into a terminal error state.

Top module: `cmdseq_top`

## Requirements
- R1: After a synchronous reset, `cmd_valid`, `sw_ack`, `sw_done`, `hw_boot`, `hw_auto`, `hw_ack`, `recov_err` and `fatal_err` are all 0.
- R2: With `en` and `boot_mode` high, the port sends the `boot_ins_word` value as a single-word command. After that command is acknowledged, it sends `boot_gen_word` the same way. After the second acknowledge, no further word is sent and `hw_boot` falls. The recommended default values are 0x0000_0901 and 0x00FF_F003.
- R3: `hw_type` shows bits [3:0] of the first word of the last hardware-issued command. `hw_ack` clears when such a command starts and sets on its acknowledge. `hw_sts` captures the returned status.
- R4: In software mode, every word accepted on `sw_wr` while `sw_rdy` is high appears on `cmd_word`, in the order written. `sw_rdy` stays low while a word is pending on the port, and from the last word of a command until its acknowledge. A command is its first word plus the number of data words given in bits [7:4] of that word.
- R5: `sw_ack` clears when the first word of a new software command is accepted and sets on its acknowledge. `sw_sts` captures the status. `sw_done` is high for exactly the one cycle after that acknowledge.
- R6: Any acknowledge whose status is not 0 sets `recov_err`, which then stays set until reset.
- R7: In auto mode (`auto_mode` high), the acknowledge of a software instantiate command (kind 1) hands the port to hardware. Hardware then sends every word of the stored generate command.
- R8: With `max_reqs` = N > 0, auto mode sends N generate commands, then one reseed command, and repeats that pattern.
- R9: In auto mode, no new command word is sent until the acknowledge for the previous command has returned.
- R10: While hardware owns the port in auto mode, `sw_wr` has no effect: it sends no word and leaves `sw_ack` unchanged.
- R11: Each replay buffer holds up to 13 words. A write to a full buffer sets `fatal_err`, which then stays set until reset.
- R12: While `buf_clr` is high, both replay buffers are emptied and writes to them are ignored. Writes are accepted again once `buf_clr` returns low.
- R13: An unrecognised state-machine code moves the block to a terminal error state. In that state `fatal_err` is set and no command word is ever sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low returns the block to idle |
| boot_mode | input | 1 | Select the fixed boot sequence |
| auto_mode | input | 1 | Hand the port to hardware after a software instantiate |
| boot_ins_word | input | 32 | Instantiate word used in boot mode |
| boot_gen_word | input | 32 | Generate word used in boot mode |
| max_reqs | input | 32 | Generate commands between reseeds |
| sw_wr | input | 1 | Software command word strobe |
| sw_word | input | 32 | Software command word |
| sw_rdy | output | 1 | A software word can be accepted |
| rsd_wr | input | 1 | Reseed buffer write strobe |
| rsd_word | input | 32 | Reseed buffer write data |
| gen_wr | input | 1 | Generate buffer write strobe |
| gen_word | input | 32 | Generate buffer write data |
| buf_clr | input | 1 | Empty both replay buffers and block writes to them |
| cmd_valid | output | 1 | Command word valid |
| cmd_word | output | 32 | Command word |
| cmd_ready | input | 1 | Generator takes the word |
| ack_valid | input | 1 | Command acknowledge |
| ack_sts | input | 2 | Acknowledge status, 0 means success |
| sw_ack | output | 1 | Last software command acknowledged |
| sw_sts | output | 2 | Status of last software command |
| sw_done | output | 1 | One-cycle software completion pulse |
| hw_boot | output | 1 | Boot sequence in progress |
| hw_auto | output | 1 | Hardware part of auto mode active |
| hw_type | output | 4 | Kind of last hardware-issued command |
| hw_ack | output | 1 | Last hardware command acknowledged |
| hw_sts | output | 2 | Status of last hardware command |
| recov_err | output | 1 | Sticky error-status flag |
| fatal_err | output | 1 | Sticky fatal flag |

## Verification
Most internal faults in this block show up at the command port within one or two cycles. A wrong replay index, a stale buffer or a countdown off by one sends the wrong word. A wrong state code either sends a word while a command is still waiting for its acknowledge, or leaves the port silent when a word is due. The bench therefore compares every word it receives with the expected command sequence, and checks that the port stays quiet through waiting windows. Status faults appear on `sw_ack`, `hw_ack` and the captured codes on the cycle right after an acknowledge, so they are sampled there.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int unsigned ST_W = 6;
  typedef logic [ST_W-1:0] st_t;

  // sparse state codes, pairwise distance of at least two
  localparam st_t ST_IDLE   = 6'b101001;
  localparam st_t ST_SEND   = 6'b010011;
  localparam st_t ST_WAIT   = 6'b110100;
  localparam st_t ST_SWCOL  = 6'b001110;
  localparam st_t ST_SWWAIT = 6'b100110;
  localparam st_t ST_BDONE  = 6'b011000;
  localparam st_t ST_ERR    = 6'b111111;

  typedef enum logic [1:0] {SRC_BINS, SRC_BGEN, SRC_AGEN, SRC_ARSD} src_e;

  localparam logic [3:0] CMD_INS = 4'd1;
  localparam logic [3:0] CMD_RSD = 4'd2;
  localparam logic [3:0] CMD_GEN = 4'd3;

  localparam logic [31:0] BOOT_INS_DEFAULT = 32'h0000_0901;
  localparam logic [31:0] BOOT_GEN_DEFAULT = 32'h00FF_F003;
endpackage

// File: rtl/cmdseq_cmdbuf.sv
module cmdseq_cmdbuf #(
  parameter int DEPTH = 13,
  parameter int W     = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          wr_ok;

  assign wr_ok = wr && !clr && (cnt_q != FULL);
  assign ovf   = wr && !clr && (cnt_q == FULL);
  assign cnt   = cnt_q;
  assign rdata = (rd_idx <= LAST) ? mem[rd_idx] : '0;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[IW'(cnt_q)] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (wr_ok) cnt_q <= cnt_q + 1'b1;
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R12
endmodule

// File: rtl/cmdseq_cntdn.sv
module cmdseq_cntdn #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] init,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= init;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
  import cmdseq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_DEPTH = 13,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              boot_mode,
  input  logic              auto_mode,
  input  logic [WORD_W-1:0] boot_ins_word,
  input  logic [WORD_W-1:0] boot_gen_word,
  input  logic [CNT_W-1:0]  max_reqs,
  input  logic              sw_wr,
  input  logic [WORD_W-1:0] sw_word,
  output logic              sw_rdy,
  input  logic              rsd_wr,
  input  logic [WORD_W-1:0] rsd_word,
  input  logic              gen_wr,
  input  logic [WORD_W-1:0] gen_word,
  input  logic              buf_clr,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_ready,
  input  logic              ack_valid,
  input  logic [1:0]        ack_sts,
  output logic              sw_ack,
  output logic [1:0]        sw_sts,
  output logic              sw_done,
  output logic              hw_boot,
  output logic              hw_auto,
  output logic [3:0]        hw_type,
  output logic              hw_ack,
  output logic [1:0]        hw_sts,
  output logic              recov_err,
  output logic              fatal_err
);
  localparam int IW    = $clog2(BUF_DEPTH);
  localparam int CW    = $clog2(BUF_DEPTH + 1);
  localparam int LEN_W = 4;

  st_t  state_q, state_d;
  src_e src_q, src_d;
  logic [LEN_W-1:0] idx_q, idx_d, len_q, hdr_len, sw_rem_q;
  logic [3:0]  sw_type_q;
  logic [WORD_W-1:0] src_word, out_word, gen_rdata, rsd_rdata, cmd_word_q;
  logic [CW-1:0] gen_cnt, rsd_cnt;
  logic gen_ovf, rsd_ovf, ctr_zero, ctr_load, ctr_dec;
  logic out_load, sw_hdr, sw_ack_set, hw_ack_set, auto_entry, hw_hdr;
  logic sw_accept, is_boot_src, is_last, src_avail, cmd_valid_q;
  logic sw_ack_q, sw_done_q, hw_boot_q, hw_auto_q, hw_ack_q, recov_q, fatal_q;
  logic [1:0] sw_sts_q, hw_sts_q;
  logic [3:0] hw_type_q;

  cmdseq_cmdbuf #(.DEPTH(BUF_DEPTH), .W(WORD_W)) i_genbuf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr(gen_wr), .wdata(gen_word),
    .rd_idx(IW'(idx_q)), .rdata(gen_rdata), .cnt(gen_cnt), .ovf(gen_ovf));

  cmdseq_cmdbuf #(.DEPTH(BUF_DEPTH), .W(WORD_W)) i_rsdbuf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr(rsd_wr), .wdata(rsd_word),
    .rd_idx(IW'(idx_q)), .rdata(rsd_rdata), .cnt(rsd_cnt), .ovf(rsd_ovf));

  cmdseq_cntdn #(.W(CNT_W)) i_cntdn (
    .clk(clk), .rst(rst), .load(ctr_load), .dec(ctr_dec),
    .init(max_reqs), .zero(ctr_zero));

  always_comb begin
    case (src_q)
      SRC_BINS: begin src_word = boot_ins_word; src_avail = 1'b1;          end
      SRC_BGEN: begin src_word = boot_gen_word; src_avail = 1'b1;          end
      SRC_AGEN: begin src_word = gen_rdata;     src_avail = gen_cnt != '0; end
      default:  begin src_word = rsd_rdata;     src_avail = rsd_cnt != '0; end
    endcase
  end

  assign is_boot_src = (src_q == SRC_BINS) || (src_q == SRC_BGEN);
  assign hdr_len     = is_boot_src ? '0 : src_word[7:4];
  assign is_last     = (idx_q == '0) ? (hdr_len == '0) : (idx_q == len_q);
  assign sw_rdy      = en && !cmd_valid_q &&
                       ((state_q == ST_IDLE && !boot_mode) || state_q == ST_SWCOL);
  assign sw_accept   = sw_wr && sw_rdy;
  assign hw_hdr      = out_load && (state_q == ST_SEND) && (idx_q == '0);
  assign ctr_load    = auto_entry || (hw_hdr && src_q == SRC_ARSD);
  assign ctr_dec     = hw_hdr && (src_q == SRC_AGEN);

  always_comb begin
    state_d = state_q; src_d = src_q; idx_d = idx_q;
    out_load = 1'b0; out_word = '0; sw_hdr = 1'b0;
    sw_ack_set = 1'b0; hw_ack_set = 1'b0; auto_entry = 1'b0;
    case (state_q)
      ST_IDLE: if (en) begin
        if (boot_mode) begin
          state_d = ST_SEND; src_d = SRC_BINS; idx_d = '0;
        end else if (sw_accept) begin
          out_load = 1'b1; out_word = sw_word; sw_hdr = 1'b1;
          state_d = (sw_word[7:4] == '0) ? ST_SWWAIT : ST_SWCOL;
        end
      end
      ST_SWCOL: if (!en) state_d = ST_IDLE;
        else if (sw_accept) begin
          out_load = 1'b1; out_word = sw_word;
          if (sw_rem_q == LEN_W'(1)) state_d = ST_SWWAIT;
        end
      ST_SWWAIT: if (!en) state_d = ST_IDLE;
        else if (ack_valid) begin
          sw_ack_set = 1'b1;
          if (auto_mode && sw_type_q == CMD_INS) begin
            auto_entry = 1'b1; state_d = ST_SEND; idx_d = '0;
            src_d = (max_reqs == '0) ? SRC_ARSD : SRC_AGEN;
          end else state_d = ST_IDLE;
        end
      ST_SEND: if (!en) state_d = ST_IDLE;
        else if (!cmd_valid_q && src_avail) begin
          out_load = 1'b1; out_word = src_word; idx_d = idx_q + 1'b1;
          if (is_last) state_d = ST_WAIT;
        end
      ST_WAIT: if (!en) state_d = ST_IDLE;
        else if (ack_valid) begin
          hw_ack_set = 1'b1; idx_d = '0;
          case (src_q)
            SRC_BINS: begin state_d = ST_SEND; src_d = SRC_BGEN; end
            SRC_BGEN: state_d = ST_BDONE;
            default: begin
              state_d = ST_SEND; src_d = ctr_zero ? SRC_ARSD : SRC_AGEN;
            end
          endcase
        end
      ST_BDONE: if (!en) state_d = ST_IDLE;
      ST_ERR: state_d = ST_ERR;
      default: state_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE; src_q <= SRC_BINS; idx_q <= '0; len_q <= '0;
      cmd_valid_q <= 1'b0; cmd_word_q <= '0;
      sw_rem_q <= '0; sw_type_q <= '0; sw_ack_q <= 1'b0; sw_sts_q <= '0;
      sw_done_q <= 1'b0; hw_boot_q <= 1'b0; hw_auto_q <= 1'b0;
      hw_type_q <= '0; hw_ack_q <= 1'b0; hw_sts_q <= '0;
      recov_q <= 1'b0; fatal_q <= 1'b0;
    end else begin
      state_q <= state_d; src_q <= src_d; idx_q <= idx_d;
      if (out_load) begin
        cmd_valid_q <= 1'b1; cmd_word_q <= out_word;
      end else if (cmd_ready || !en) cmd_valid_q <= 1'b0;
      if (hw_hdr) begin
        len_q <= hdr_len; hw_type_q <= src_word[3:0]; hw_ack_q <= 1'b0;
      end
      if (sw_hdr) begin
        sw_ack_q <= 1'b0; sw_type_q <= sw_word[3:0]; sw_rem_q <= sw_word[7:4];
      end else if (sw_accept) sw_rem_q <= sw_rem_q - 1'b1;
      if (sw_ack_set) begin sw_ack_q <= 1'b1; sw_sts_q <= ack_sts; end
      if (hw_ack_set) begin hw_ack_q <= 1'b1; hw_sts_q <= ack_sts; end
      sw_done_q <= sw_ack_set;
      hw_boot_q <= (state_d == ST_SEND || state_d == ST_WAIT) &&
                   (src_d == SRC_BINS || src_d == SRC_BGEN);
      hw_auto_q <= (state_d == ST_SEND || state_d == ST_WAIT) &&
                   (src_d == SRC_AGEN || src_d == SRC_ARSD);
      if ((sw_ack_set || hw_ack_set) && ack_sts != 2'b00) recov_q <= 1'b1;
      if (gen_ovf || rsd_ovf || state_q == ST_ERR) fatal_q <= 1'b1;
    end
  end

  assign cmd_valid = cmd_valid_q;
  assign cmd_word  = cmd_word_q;
  assign sw_ack    = sw_ack_q;
  assign sw_sts    = sw_sts_q;
  assign sw_done   = sw_done_q;
  assign hw_boot   = hw_boot_q;
  assign hw_auto   = hw_auto_q;
  assign hw_type   = hw_type_q;
  assign hw_ack    = hw_ack_q;
  assign hw_sts    = hw_sts_q;
  assign recov_err = recov_q;
  assign fatal_err = fatal_q;

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && en) |=> (cmd_valid && $stable(cmd_word))); // R4
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |=> !$rose(cmd_valid_q)); // R9
  AST_SW_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND || state_q == ST_WAIT) |-> !sw_rdy); // R10
  AST_RECOV_STICKY: assert property (@(posedge clk) disable iff (rst)
    recov_q |=> recov_q); // R6
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q); // R11
  AST_ERR_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERR) |=> (state_q == ST_ERR && !cmd_valid_q)); // R13
endmodule

// File: tb/test_cmdseq_top.sv
`timescale 1ns/1ps
module test_cmdseq_top;
  import cmdseq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, boot_mode = 0, auto_mode = 0;
  logic [31:0] boot_ins_word = BOOT_INS_DEFAULT, boot_gen_word = BOOT_GEN_DEFAULT;
  logic [31:0] max_reqs = 0;
  logic sw_wr = 0, rsd_wr = 0, gen_wr = 0, buf_clr = 0;
  logic [31:0] sw_word = 0, rsd_word = 0, gen_word = 0;
  logic cmd_ready = 1'b1, ack_valid = 0;
  logic [1:0] ack_sts = 0;
  logic sw_rdy, cmd_valid, sw_ack, sw_done, hw_boot, hw_auto, hw_ack, recov_err, fatal_err;
  logic [31:0] cmd_word;
  logic [1:0] sw_sts, hw_sts;
  logic [3:0] hw_type;

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  cmdseq_top i_cmdseq_top (
    .clk(clk), .rst(rst), .en(en), .boot_mode(boot_mode), .auto_mode(auto_mode),
    .boot_ins_word(boot_ins_word), .boot_gen_word(boot_gen_word), .max_reqs(max_reqs),
    .sw_wr(sw_wr), .sw_word(sw_word), .sw_rdy(sw_rdy),
    .rsd_wr(rsd_wr), .rsd_word(rsd_word), .gen_wr(gen_wr), .gen_word(gen_word),
    .buf_clr(buf_clr), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .ack_valid(ack_valid), .ack_sts(ack_sts), .sw_ack(sw_ack), .sw_sts(sw_sts),
    .sw_done(sw_done), .hw_boot(hw_boot), .hw_auto(hw_auto), .hw_type(hw_type),
    .hw_ack(hw_ack), .hw_sts(hw_sts), .recov_err(recov_err), .fatal_err(fatal_err));

  // {first word, data base, ack status}; data word k is base + k
  localparam logic [65:0] SW_VEC [4] = '{
    {32'h0000_0001, 32'h0000_0000, 2'b00},
    {32'h0000_0023, 32'hA000_0000, 2'b00},
    {32'h0000_0012, 32'hB000_0000, 2'b10},
    {32'h0000_0034, 32'hC000_0000, 2'b01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en = 0; boot_mode = 0; auto_mode = 0; sw_wr = 0; rsd_wr = 0;
    gen_wr = 0; buf_clr = 0; ack_valid = 0; max_reqs = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic sw_write(input logic [31:0] w);
    @(negedge clk);
    while (!sw_rdy) @(negedge clk);
    sw_wr = 1; sw_word = w;
    @(negedge clk);
    sw_wr = 0;
  endtask

  task automatic buf_write(input bit to_gen, input logic [31:0] w);
    @(negedge clk);
    if (to_gen) begin gen_wr = 1; gen_word = w; end
    else begin rsd_wr = 1; rsd_word = w; end
    @(negedge clk);
    gen_wr = 0; rsd_wr = 0;
  endtask

  task automatic get_word(input string req, input logic [31:0] exp);
    int n = 0;
    while (!cmd_valid && n < 100) begin @(negedge clk); n++; end
    chk(req, cmd_valid ? cmd_word : 32'hDEAD_BEEF, exp);
    @(negedge clk);
  endtask

  task automatic send_ack(input logic [1:0] s);
    ack_valid = 1; ack_sts = s;
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic quiet(input string req, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      if (cmd_valid) seen++;
      @(negedge clk);
    end
    chk(req, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic exp_recov;
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 flags", {sw_ack, sw_done, hw_boot, hw_auto, hw_ack, recov_err, fatal_err}, 0);

    // R4 R5 R6: software command table
    en = 1; exp_recov = 0;
    for (int v = 0; v < 4; v++) begin
      logic [31:0] hdr;
      hdr = SW_VEC[v][65:34];
      sw_write(hdr);
      chk("R5 sw_ack cleared", sw_ack, 0);
      get_word("R4 first word", hdr);
      for (int k = 0; k < int'(hdr[7:4]); k++) begin
        sw_write(SW_VEC[v][33:2] + 32'(k));
        get_word("R4 data word", SW_VEC[v][33:2] + 32'(k));
      end
      chk("R4 sw_rdy low awaiting ack", sw_rdy, 0);
      send_ack(SW_VEC[v][1:0]);
      exp_recov = exp_recov | (SW_VEC[v][1:0] != 2'b00);
      chk("R5 sw_ack", sw_ack, 1);
      chk("R5 sw_sts", sw_sts, SW_VEC[v][1:0]);
      chk("R5 sw_done pulse", sw_done, 1);
      chk("R6 recov_err", recov_err, exp_recov);
      @(negedge clk);
      chk("R5 sw_done one cycle", sw_done, 0);
    end

    // R2 R3 R6: boot sequence with default words
    do_reset();
    en = 1; boot_mode = 1;
    get_word("R2 boot instantiate", 32'h0000_0901);
    chk("R2 hw_boot", hw_boot, 1);
    chk("R3 hw_type ins", hw_type, 1);
    chk("R3 hw_ack cleared", hw_ack, 0);
    send_ack(2'b00);
    chk("R3 hw_ack set", hw_ack, 1);
    chk("R6 recov clean", recov_err, 0);
    get_word("R2 boot generate", 32'h00FF_F003);
    chk("R3 hw_type gen", hw_type, 3);
    send_ack(2'b01);
    chk("R3 hw_sts", hw_sts, 1);
    chk("R6 recov after error status", recov_err, 1);
    quiet("R2 nothing after boot", 20);
    chk("R2 hw_boot low", hw_boot, 0);

    // R2: boot words come from the inputs
    do_reset();
    boot_ins_word = 32'h0000_5A01; boot_gen_word = 32'h0012_3403;
    en = 1; boot_mode = 1;
    get_word("R2 custom instantiate", 32'h0000_5A01);
    send_ack(2'b00);
    get_word("R2 custom generate", 32'h0012_3403);
    send_ack(2'b00);

    // R7 R8 R9 R10: auto replay
    do_reset();
    buf_write(1, 32'h0000_0013); buf_write(1, 32'hDEAD_0001);
    buf_write(0, 32'h0000_0002);
    max_reqs = 2; auto_mode = 1; en = 1;
    sw_write(32'h0000_0001);
    get_word("R7 sw instantiate", 32'h0000_0001);
    send_ack(2'b00);
    chk("R7 sw_ack", sw_ack, 1);
    for (int r = 0; r < 2; r++) begin
      for (int g = 0; g < 2; g++) begin
        get_word("R7 gen header", 32'h0000_0013);
        chk("R8 hw_type gen", hw_type, 3);
        chk("R7 hw_auto", hw_auto, 1);
        get_word("R7 gen data", 32'hDEAD_0001);
        if (r == 0 && g == 0) quiet("R9 wait for ack", 10);
        if (r == 0 && g == 1) begin
          sw_wr = 1; sw_word = 32'h0000_0003;
          @(negedge clk);
          sw_wr = 0;
          chk("R10 sw_ack kept", sw_ack, 1);
          quiet("R10 no word from sw", 3);
        end
        send_ack(2'b00);
      end
      get_word("R8 reseed", 32'h0000_0002);
      chk("R8 hw_type rsd", hw_type, 2);
      send_ack(2'b00);
    end

    // R12: clear empties buffers and blocks writes
    do_reset();
    buf_write(1, 32'h0000_0013); buf_write(1, 32'hDEAD_0001);
    @(negedge clk); buf_clr = 1;
    buf_write(1, 32'h0000_0023);
    @(negedge clk); buf_clr = 0;
    buf_write(1, 32'h0000_0003); buf_write(0, 32'h0000_0002);
    max_reqs = 5; auto_mode = 1; en = 1;
    sw_write(32'h0000_0001);
    get_word("R12 sw instantiate", 32'h0000_0001);
    send_ack(2'b00);
    get_word("R12 new gen only", 32'h0000_0003);
    send_ack(2'b00);
    get_word("R12 new gen again", 32'h0000_0003);
    send_ack(2'b00);

    // R11: overflow of a replay buffer
    do_reset();
    for (int i = 0; i < 13; i++) buf_write(0, 32'(i));
    chk("R11 no fatal at full", fatal_err, 0);
    buf_write(0, 32'h0000_00FF);
    chk("R11 fatal on overflow", fatal_err, 1);
    quiet("R11 fatal sticky", 2);
    chk("R11 fatal still set", fatal_err, 1);

    // R13: illegal state code
    do_reset();
    @(negedge clk);
    force i_cmdseq_top.state_q = 6'b000000;
    @(negedge clk);
    release i_cmdseq_top.state_q;
    en = 1; boot_mode = 1;
    repeat (3) @(negedge clk);
    chk("R13 fatal", fatal_err, 1);
    quiet("R13 no command words", 20);

    summary();
  end
endmodule